// File: doc/BRIEF.md
# Three-Port Parallel Interface Register Decoder

This block is the processor-facing register side of a 24-line parallel interface. The interface has three 8-bit ports (A, B and C), and port C is split into an upper and a lower nibble. A host selects the block with an active-low chip select and picks a register with a 2-bit address. It then pulses an active-low read or write strobe. Writes to the port addresses load output latches. A write to the control address does one of two things, chosen by data bit 7: it either redefines the direction and mode of every port, or it forces a single port C line high or low.

The block sits next to the pad ring. It drives latched output values and one output enable per port (two for port C, one per nibble) to external tristate pads. It receives the live pin levels back on separate input buses. The host data bus is modelled as separate input and output buses plus a read-enable flag. The strobes are plain level signals with no back-pressure, and the host must hold address, data and chip select steady for the whole low phase of a strobe. The write strobe is synchronised to the block clock. Handshake modes 1 and 2 are only decoded onto mode outputs; no handshake behaviour is built.

Top module: `pport_regs`

## Requirements
- R1: After reset every output enable is low (all ports input), all output latches are 0 and both mode outputs are 0.
- R2: A write to address 3 with data bit 7 = 1 sets the port directions. Bit 4 controls port A, bit 3 upper C, bit 1 port B and bit 0 lower C. A value of 1 means input (enable low) and 0 means output (enable high). So 0x83 gives A and upper C as outputs, 0x98 gives A and upper C as inputs, and 0x80 gives all outputs.
- R3: Such a direction write also clears all three output latches to 0.
- R4: A write to address 0, 1 or 2 stores the data byte into the port A, B or C output latch.
- R5: A write to address 3 with bit 7 = 0 changes only port C line number bits[3:1], setting it to bit 0. Bits 6:4 are ignored and the directions and modes stay unchanged, so 0x0B sets line 5 and 0x7F sets line 7.
- R6: A read of address 0 or 1 returns the live pins of a port programmed as input, and the latch of a port programmed as output.
- R7: A read of address 2 returns, per nibble, the pins if that nibble is an input and the latch if it is an output.
- R8: A read of address 3 returns 0.
- R9: With chip select high, writes change nothing and the read-enable flag stays low. The read-enable flag is high only while both chip select and read strobe are low.
- R10: One write strobe causes exactly one register update, captured when the synchronised strobe first goes active. Data changed later in the same strobe is not stored.
- R11: A direction write also copies bits 6:5 to the group A mode output and bit 2 to the group B mode output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 2 | Register select (0 A, 1 B, 2 C, 3 control) |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_oe | output | 1 | Host read data valid / bus drive enable |
| pa_in | input | 8 | Port A pin levels |
| pb_in | input | 8 | Port B pin levels |
| pc_in | input | 8 | Port C pin levels |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_oe | output | 1 | Port A pad drive enable |
| pb_oe | output | 1 | Port B pad drive enable |
| pc_hi_oe | output | 1 | Port C upper nibble drive enable |
| pc_lo_oe | output | 1 | Port C lower nibble drive enable |
| grpa_mode | output | 2 | Decoded group A mode |
| grpb_mode | output | 1 | Decoded group B mode |

## Verification
Several properties are checked on every cycle: the write pulse never lasts two cycles, a direction write always leaves the latches at zero, a bit command lands on the addressed line and leaves the directions and modes alone, a deselected cycle never moves a latch, and a control-address read returns zero. The bench scenarios are needed to show the exact direction encodings, the per-nibble read mix of port C, the reset state, and that data changed part-way through a long strobe is not stored.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PORT_W = 8;
  localparam int NIB_W  = PORT_W / 2;
  localparam int IDX_W  = $clog2(PORT_W);

  localparam logic [1:0] ADDR_A   = 2'd0;
  localparam logic [1:0] ADDR_B   = 2'd1;
  localparam logic [1:0] ADDR_C   = 2'd2;
  localparam logic [1:0] ADDR_CTL = 2'd3;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       chi_in;
    logic       b_mode;
    logic       b_in;
    logic       clo_in;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{a_mode: 2'd0, a_in: 1'b1, chi_in: 1'b1,
                                 b_mode: 1'b0, b_in: 1'b1, clo_in: 1'b1};
endpackage

// File: rtl/pport_strobe_sync.sv
module pport_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic pulse
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-1:0], ~strobe_n};
  end

  assign pulse = shreg[STAGES-1] & ~shreg[STAGES];

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/pport_ctrl_reg.sv
module pport_ctrl_reg
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PORT_W-1:0] wdata,
  output ctl_t              ctl,
  output logic              mode_we,
  output logic              bsr_we,
  output logic [IDX_W-1:0]  bsr_idx,
  output logic              bsr_val
);
  assign mode_we = we &  wdata[PORT_W-1];
  assign bsr_we  = we & ~wdata[PORT_W-1];
  assign bsr_idx = wdata[IDX_W:1];
  assign bsr_val = wdata[0];

  always_ff @(posedge clk) begin
    if (rst) ctl <= CTL_RESET;
    else if (mode_we) ctl <= ctl_t'(wdata[6:0]);
  end

  assert_bsr_keeps_mode_R5: assert property (@(posedge clk) disable iff (rst)
    bsr_we |=> (ctl == $past(ctl)));
endmodule

// File: rtl/pport_port_latch.sv
module pport_port_latch #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  input  logic          bit_en,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (wr_en) q <= wdata;
    else if (bit_en) q[bit_idx] <= bit_val;
  end

  assert_mode_clear_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));
  assert_bit_update_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !clr && !wr_en) |=> (q[$past(bit_idx)] == $past(bit_val)));
endmodule

// File: rtl/pport_read_mux.sv
module pport_read_mux
  import pport_pkg::*;
(
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  ctl_t              ctl,
  input  logic [PORT_W-1:0] pa_pin,
  input  logic [PORT_W-1:0] pb_pin,
  input  logic [PORT_W-1:0] pc_pin,
  input  logic [PORT_W-1:0] pa_q,
  input  logic [PORT_W-1:0] pb_q,
  input  logic [PORT_W-1:0] pc_q,
  output logic [PORT_W-1:0] rdata,
  output logic              rvalid
);
  logic [PORT_W-1:0] a_view, b_view, c_view;

  assign a_view = ctl.a_in ? pa_pin : pa_q;
  assign b_view = ctl.b_in ? pb_pin : pb_q;
  assign c_view = {ctl.chi_in ? pc_pin[PORT_W-1:NIB_W] : pc_q[PORT_W-1:NIB_W],
                   ctl.clo_in ? pc_pin[NIB_W-1:0]      : pc_q[NIB_W-1:0]};

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        ADDR_A:  rdata = a_view;
        ADDR_B:  rdata = b_view;
        ADDR_C:  rdata = c_view;
        default: rdata = '0;
      endcase
    end
  end

  assign rvalid = rd_en;
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [1:0]        addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [PORT_W-1:0] din,
  output logic [PORT_W-1:0] dout,
  output logic              dout_oe,
  input  logic [PORT_W-1:0] pa_in,
  input  logic [PORT_W-1:0] pb_in,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pc_out,
  output logic              pa_oe,
  output logic              pb_oe,
  output logic              pc_hi_oe,
  output logic              pc_lo_oe,
  output logic [1:0]        grpa_mode,
  output logic              grpb_mode
);
  localparam int NPORT = 3;

  logic              wr_pulse, wr_go;
  logic              mode_we, bsr_we, bsr_val;
  logic [IDX_W-1:0]  bsr_idx;
  ctl_t              ctl;
  logic [PORT_W-1:0] latch_q [NPORT];

  pport_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .strobe_n(wr_n), .pulse(wr_pulse)
  );

  assign wr_go = wr_pulse & ~cs_n;

  pport_ctrl_reg u_ctl (
    .clk(clk), .rst(rst), .we(wr_go && addr == ADDR_CTL), .wdata(din),
    .ctl(ctl), .mode_we(mode_we), .bsr_we(bsr_we),
    .bsr_idx(bsr_idx), .bsr_val(bsr_val)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    pport_port_latch #(.W(PORT_W)) u_latch (
      .clk(clk), .rst(rst), .clr(mode_we),
      .wr_en(wr_go && addr == 2'(i)), .wdata(din),
      .bit_en((i == NPORT - 1) ? bsr_we : 1'b0),
      .bit_idx(bsr_idx), .bit_val(bsr_val),
      .q(latch_q[i])
    );
  end

  pport_read_mux u_rd (
    .rd_en(~cs_n & ~rd_n), .addr(addr), .ctl(ctl),
    .pa_pin(pa_in), .pb_pin(pb_in), .pc_pin(pc_in),
    .pa_q(latch_q[0]), .pb_q(latch_q[1]), .pc_q(latch_q[2]),
    .rdata(dout), .rvalid(dout_oe)
  );

  assign pa_out    = latch_q[0];
  assign pb_out    = latch_q[1];
  assign pc_out    = latch_q[2];
  assign pa_oe     = ~ctl.a_in;
  assign pb_oe     = ~ctl.b_in;
  assign pc_hi_oe  = ~ctl.chi_in;
  assign pc_lo_oe  = ~ctl.clo_in;
  assign grpa_mode = ctl.a_mode;
  assign grpb_mode = ctl.b_mode;

  assert_cs_gate_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));
  assert_ctl_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && addr == ADDR_CTL) |-> (dout == '0));
endmodule

// File: tb/sim_pport_regs.sv
module sim_pport_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // {is_write, addr, wdata, pa_pin, pb_pin, pc_pin, expected_read}
  localparam logic [42:0] VECS [NVEC] = '{
    {1'b1, 2'd3, 8'h83, 24'h000000, 8'h00},
    {1'b1, 2'd0, 8'h5A, 24'h000000, 8'h00},
    {1'b0, 2'd0, 8'h00, 24'hFF0000, 8'h5A},   // R6 A output -> latch
    {1'b0, 2'd1, 8'h00, 24'h003C00, 8'h3C},   // R6 B input -> pins
    {1'b1, 2'd2, 8'hF0, 24'h000000, 8'h00},
    {1'b0, 2'd2, 8'h00, 24'h0000A5, 8'hF5},   // R7 hi latch, lo pins
    {1'b1, 2'd3, 8'h0A, 24'h000000, 8'h00},   // clear line 5
    {1'b0, 2'd2, 8'h00, 24'h000000, 8'hD0},   // R5
    {1'b1, 2'd3, 8'h98, 24'h000000, 8'h00},
    {1'b0, 2'd0, 8'h00, 24'h770000, 8'h77},   // R6 A input
    {1'b1, 2'd1, 8'h81, 24'h000000, 8'h00},
    {1'b0, 2'd1, 8'h00, 24'h00FF00, 8'h81},   // R4/R6 B output
    {1'b0, 2'd2, 8'h00, 24'h00009E, 8'h90},   // R7 hi pins, lo cleared latch
    {1'b0, 2'd3, 8'h00, 24'hFFFFFF, 8'h00}    // R8
  };

  logic clk = 0, rst = 1;
  logic cs_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] din = 0, pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] dout, pa_out, pb_out, pc_out;
  logic dout_oe, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe, grpb_mode;
  logic [1:0] grpa_mode;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pport_regs u0 (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [1:0] a, logic [7:0] d, logic sel_n = 0);
    @(negedge clk);
    cs_n = sel_n; addr = a; din = d; wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1; cs_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(logic [1:0] a, logic [23:0] pins, output logic [7:0] v);
    @(negedge clk);
    {pa_in, pb_in, pc_in} = pins;
    cs_n = 0; addr = a; rd_n = 0;
    #(CLK_PERIOD/4);
    v = dout;
    @(negedge clk);
    rd_n = 1; cs_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", {4'b0, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe}, 8'h00);
    check("R1 latches", pa_out | pb_out | pc_out, 8'h00);
    check("R1 modes", {5'b0, grpa_mode, grpb_mode}, 8'h00);
    check("R9 idle oe", {7'b0, dout_oe}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i][42]) do_write(VECS[i][41:40], VECS[i][39:32]);
      else begin
        do_read(VECS[i][41:40], VECS[i][31:8], rv);
        check($sformatf("R4/R5/R6/R7/R8 vec%0d", i), rv, VECS[i][7:0]);
      end
    end

    // R2 encodings
    do_write(2'd3, 8'h83);
    check("R2 0x83", {4'b0, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe}, 8'h0A);
    do_write(2'd0, 8'h11); do_write(2'd1, 8'h22); do_write(2'd2, 8'h33);
    check("R4 latches", pa_out ^ pb_out ^ pc_out, 8'h00);
    check("R4 portC", pc_out, 8'h33);
    do_write(2'd3, 8'h98);
    check("R2 0x98", {4'b0, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe}, 8'h05);
    check("R3 cleared", pa_out | pb_out | pc_out, 8'h00);
    do_write(2'd3, 8'h80);
    check("R2 0x80", {4'b0, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe}, 8'h0F);

    // R11 mode fields
    do_write(2'd3, 8'hC4);
    check("R11 grpa", {6'b0, grpa_mode}, 8'h02);
    check("R11 grpb", {7'b0, grpb_mode}, 8'h01);

    // R5 bit commands, D6:D4 ignored, modes kept
    do_write(2'd3, 8'h0B);
    check("R5 set line5", pc_out, 8'h20);
    do_write(2'd3, 8'h7F);
    check("R5 set line7", pc_out, 8'hA0);
    check("R5 mode kept", {5'b0, grpa_mode, grpb_mode}, 8'h05);
    check("R5 dir kept", {4'b0, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe}, 8'h0F);
    do_write(2'd3, 8'h0A);
    check("R5 clear line5", pc_out, 8'h80);

    // R9 deselected write ignored, no read enable
    do_write(2'd0, 8'hEE, 1'b1);
    check("R9 cs write", pa_out, 8'h00);
    @(negedge clk); cs_n = 1; rd_n = 0; #(CLK_PERIOD/4);
    check("R9 cs read oe", {7'b0, dout_oe}, 8'h00);
    @(negedge clk); rd_n = 1;

    // R10 long strobe, data changes mid-strobe
    @(negedge clk);
    cs_n = 0; addr = 2'd1; din = 8'h3C; wr_n = 0;
    repeat (5) @(negedge clk);
    din = 8'hC3;
    repeat (5) @(negedge clk);
    wr_n = 1; cs_n = 1;
    repeat (3) @(negedge clk);
    check("R10 single capture", pb_out, 8'h3C);

    // R1 reset again
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    check("R1 re-reset oe", {4'b0, pa_oe, pb_oe, pc_hi_oe, pc_lo_oe}, 8'h00);
    check("R1 re-reset latch", pb_out | pc_out, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule